// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transceiver

This block is the keyboard end of a two-wire PS/2 link. Both wires are open-collector with pull-ups on the host side. The block never drives a wire high. For each wire it has a single pull-down enable, and releasing that enable lets the host resistor pull the wire up. The device always generates the bit clock. It shapes every clock pulse with its own setup, low and high phases, and each phase length is a parameter counted in system clock cycles.

To receive, the block waits for the host's request to send: clock high, data low. It then issues one clock pulse per bit and samples the data wire in the released half of each pulse. After eight data bits (least significant first), an odd-parity bit and a stop bit, it gives one extra pulse while holding data low to acknowledge the frame. A good frame is handed upstream as a one-cycle valid strobe. A bad frame raises a one-cycle error strobe instead.

To transmit, the block takes a byte through a valid/ready handshake, but only while both wires read high. It then waits a settling time and shifts out a start bit, the byte, the parity bit and a stop bit. If the host pulls the clock low while the block has released it, the transmission stops at once. Both wires are released and a one-cycle failure strobe is given.

Top module: `ps2_dev_xcvr`

## Requirements
- R1: After reset and whenever the block is idle, both pull-down enables are 0 and tx_ready is 1 exactly when both synchronised lines read high.
- R2: A request to send (clock line high, data line low) seen while idle starts a reception. While a reception is in progress, tx_ready is 0.
- R3: Every receive bit is one clock pulse. The pulse has T_SETUP released cycles, then T_LOW cycles of clock pull-down, then T_HOLD released cycles (the data line is sampled at the end of these), then T_REST released cycles. Consecutive pulses are therefore separated by T_HOLD+T_REST+T_SETUP released cycles.
- R4: The first ten received bits are data bit 0 through data bit 7, then parity, then stop. If the parity bit makes the count of ones in data plus parity odd and the stop bit is 1, rx_data shows the byte and rx_valid is 1 for exactly one cycle.
- R5: If the parity bit gives an even count of ones, or the stop bit is 0, rx_err is 1 for one cycle and rx_valid stays 0.
- R6: During the eleventh receive pulse (the acknowledge), the data pull-down is 1 from the start of that pulse until the clock is released.
- R7: A byte is accepted when tx_valid and tx_ready are both 1. The data pull-down (start bit 0) appears T_WAIT+1 cycles after the cycle in which the byte was offered.
- R8: The transmitted line values, sampled while the clock is pulled low, are 0, then data bit 0 through data bit 7, then the odd-parity bit, then 1. tx_done then pulses for one cycle and both lines are released.
- R9: Every transmit bit sets data T_SETUP cycles before the clock goes low, then holds the clock low for T_LOW cycles, then releases it for T_HIGH cycles. The data enable changes only while the clock has been released for at least one cycle.
- R10: If the host holds the clock low while a transmit has it released, tx_fail pulses for one cycle, both enables return to 0 and tx_done does not pulse. tx_ready stays 0 until the host releases the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock wire |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data wire |
| ps2_clk_pull | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_dat_pull | output | 1 | 1 pulls the data wire low, 0 releases it |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Idle with both lines high; byte accepted this cycle if valid |
| tx_done | output | 1 | One-cycle strobe: frame fully sent |
| tx_fail | output | 1 | One-cycle strobe: host aborted the transmission |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a good byte |
| rx_err | output | 1 | One-cycle strobe: received frame failed parity or stop check |

## Verification
A wrong bit index or a shift register that moves too early shows up as a wrong line value on the very next clock pulse. It is therefore caught within one bit time, by comparing the whole frame against a frame built arithmetically from the byte. A stuck phase counter shows up immediately as a wrong low-pulse length or inter-pulse gap, and every pulse of every frame is measured. Every byte value is sent in both directions, so a parity or ordering fault cannot hide behind a particular data pattern. A missed abort shows up within a few cycles: a clock pulse appears while the host holds the line, or tx_fail never arrives.

// File: rtl/ps2x_pkg.sv
package ps2x_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_WAIT,
    ST_TX_SETUP,
    ST_TX_LOW,
    ST_TX_HIGH,
    ST_RX_SETUP,
    ST_RX_LOW,
    ST_RX_HOLD,
    ST_RX_REST
  } ps2x_state_e;

  // number of clock pulses per frame in either direction
  localparam int FRAME_PULSES = 11;
  // index of the last pulse (stop on transmit, acknowledge on receive)
  localparam int LAST_IDX     = FRAME_PULSES - 1;

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  // start(0) in bit 0, then data LSB first, parity, stop(1)
  function automatic logic [10:0] tx_frame(input logic [7:0] d);
    return {1'b1, odd_par(d), d, 1'b0};
  endfunction

  // bits 7:0 data, 8 parity, 9 stop
  function automatic logic rx_frame_ok(input logic [9:0] f);
    return f[9] && (f[8] == odd_par(f[7:0]));
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps2x_sync.sv
module ps2x_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        stab_q <= 1'b1;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end
    assign sync_out[i] = stab_q;
  end
endmodule

// File: rtl/ps2x_timer.sv
module ps2x_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ps2_dev_xcvr.sv
module ps2_dev_xcvr
  import ps2x_pkg::*;
#(
  parameter int T_SETUP = 250,
  parameter int T_LOW   = 1750,
  parameter int T_HOLD  = 250,
  parameter int T_REST  = 1250,
  parameter int T_HIGH  = 1500,
  parameter int T_WAIT  = 2500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_pull,
  output logic       ps2_dat_pull,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       tx_fail,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_err
);

  localparam int MAXD = max2(max2(max2(T_SETUP, T_LOW), max2(T_HOLD, T_REST)),
                             max2(T_HIGH, T_WAIT));
  localparam int TW   = $clog2(MAXD + 1);

  function automatic logic [TW-1:0] dur(input int d);
    return TW'(d - 1);
  endfunction

  // synchronised line levels
  logic s_clk, s_dat;
  ps2x_sync #(.N(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ps2_clk_in, ps2_dat_in}),
    .sync_out ({s_clk, s_dat})
  );

  ps2x_state_e state_q, state_d;
  logic          tmr_ld;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  ps2x_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  logic [3:0]  bit_idx_q;
  logic [10:0] tx_sh_q;
  logic [9:0]  rx_sh_q;
  logic        pull_d1_q, pull_d2_q;

  // named internal events
  logic is_idle, host_req, tx_accept, tx_rel, host_abort, last_bit, rx_good;
  assign is_idle    = (state_q == ST_IDLE);
  assign host_req   = is_idle && s_clk && !s_dat;
  assign tx_accept  = tx_valid && tx_ready;
  assign tx_rel     = (state_q == ST_TX_WAIT) || (state_q == ST_TX_SETUP) ||
                      (state_q == ST_TX_HIGH);
  // the synchronised clock reflects our own enable of two cycles ago
  assign host_abort = tx_rel && !s_clk && !pull_d2_q;
  assign last_bit   = (bit_idx_q == 4'(LAST_IDX));
  assign rx_good    = rx_frame_ok(rx_sh_q);

  assign tx_ready     = is_idle && s_clk && s_dat;
  assign ps2_clk_pull = (state_q == ST_TX_LOW) || (state_q == ST_RX_LOW);
  assign ps2_dat_pull =
      (((state_q == ST_TX_SETUP) || (state_q == ST_TX_LOW) || (state_q == ST_TX_HIGH))
        && !tx_sh_q[0]) ||
      (((state_q == ST_RX_SETUP) || (state_q == ST_RX_LOW) || (state_q == ST_RX_HOLD))
        && last_bit);

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          state_d = ST_RX_SETUP; tmr_ld = 1'b1; tmr_val = dur(T_SETUP);
        end else if (tx_accept) begin
          state_d = ST_TX_WAIT;  tmr_ld = 1'b1; tmr_val = dur(T_WAIT);
        end
      end
      ST_TX_WAIT, ST_TX_SETUP, ST_TX_HIGH: begin
        if (host_abort) begin
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          if (state_q == ST_TX_SETUP) begin
            state_d = ST_TX_LOW; tmr_ld = 1'b1; tmr_val = dur(T_LOW);
          end else if (state_q == ST_TX_HIGH && last_bit) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_TX_SETUP; tmr_ld = 1'b1; tmr_val = dur(T_SETUP);
          end
        end
      end
      ST_TX_LOW: if (tmr_zero) begin
        state_d = ST_TX_HIGH; tmr_ld = 1'b1; tmr_val = dur(T_HIGH);
      end
      ST_RX_SETUP: if (tmr_zero) begin
        state_d = ST_RX_LOW; tmr_ld = 1'b1; tmr_val = dur(T_LOW);
      end
      ST_RX_LOW: if (tmr_zero) begin
        state_d = ST_RX_HOLD; tmr_ld = 1'b1; tmr_val = dur(T_HOLD);
      end
      ST_RX_HOLD: if (tmr_zero) begin
        state_d = ST_RX_REST; tmr_ld = 1'b1; tmr_val = dur(T_REST);
      end
      ST_RX_REST: if (tmr_zero) begin
        if (last_bit) state_d = ST_IDLE;
        else begin
          state_d = ST_RX_SETUP; tmr_ld = 1'b1; tmr_val = dur(T_SETUP);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_idx_q <= '0;
      tx_sh_q   <= '1;
      rx_sh_q   <= '0;
      pull_d1_q <= 1'b0;
      pull_d2_q <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_err    <= 1'b0;
      tx_done   <= 1'b0;
      tx_fail   <= 1'b0;
    end else begin
      state_q   <= state_d;
      pull_d1_q <= ps2_clk_pull;
      pull_d2_q <= pull_d1_q;
      rx_valid  <= 1'b0;
      rx_err    <= 1'b0;
      tx_done   <= 1'b0;
      tx_fail   <= host_abort;
      if (host_req) begin
        bit_idx_q <= '0;
      end else if (is_idle && tx_accept) begin
        bit_idx_q <= '0;
        tx_sh_q   <= tx_frame(tx_data);
      end
      if (state_q == ST_TX_HIGH && tmr_zero && !host_abort) begin
        if (last_bit) tx_done <= 1'b1;
        else begin
          bit_idx_q <= bit_idx_q + 1'b1;
          tx_sh_q   <= {1'b1, tx_sh_q[10:1]};
        end
      end
      if (state_q == ST_RX_HOLD && tmr_zero && !last_bit)
        rx_sh_q <= {s_dat, rx_sh_q[9:1]};
      if (state_q == ST_RX_REST && tmr_zero) begin
        if (last_bit) begin
          rx_valid <= rx_good;
          rx_err   <= !rx_good;
          rx_data  <= rx_sh_q[7:0];
        end else begin
          bit_idx_q <= bit_idx_q + 1'b1;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  logic [TW:0] low_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_len_q <= '0;
    else if (ps2_clk_pull) low_len_q <= low_len_q + 1'b1;
    else                   low_len_q <= '0;
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> (!ps2_clk_pull && !ps2_dat_pull));

  // R3 R9
  clk_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps2_clk_pull && pull_d1_q) |-> (low_len_q == (TW+1)'(T_LOW)));

  // R9
  dat_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_dat_pull != $past(ps2_dat_pull)) |-> (!ps2_clk_pull && !pull_d1_q));

  // R5
  rx_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |-> (!tx_done && !ps2_clk_pull && !ps2_dat_pull));

endmodule

// File: tb/test_ps2_dev_xcvr.sv
module test_ps2_dev_xcvr;

  localparam int T_SETUP = 3;
  localparam int T_LOW   = 6;
  localparam int T_HOLD  = 2;
  localparam int T_REST  = 4;
  localparam int T_HIGH  = 5;
  localparam int T_WAIT  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic host_clk = 1'b1, host_dat = 1'b1;
  logic clk_pull, dat_pull;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, tx_done, tx_fail, rx_valid, rx_err;
  logic [7:0] rx_data;

  wire line_clk = host_clk & ~clk_pull;
  wire line_dat = host_dat & ~dat_pull;

  ps2_dev_xcvr #(
    .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HOLD(T_HOLD),
    .T_REST(T_REST), .T_HIGH(T_HIGH), .T_WAIT(T_WAIT)
  ) i_ps2_dev_xcvr (
    .clk(clk), .rst_n(rst_n),
    .ps2_clk_in(line_clk), .ps2_dat_in(line_dat),
    .ps2_clk_pull(clk_pull), .ps2_dat_pull(dat_pull),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_done(tx_done), .tx_fail(tx_fail),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_tx(input logic [7:0] b);
    logic [10:0] f;
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = b[i];
    f[9]  = (ones % 2 == 0);
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    int n, gap, lowc;
    logic [10:0] got;
    bit seen;
    while (!tx_ready) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0; n = 1;
    while (!dat_pull && !clk_pull) begin @(negedge clk); n++; end
    // R7
    chk(n == T_WAIT + 1, "R7 start delay", n, T_WAIT + 1);
    for (int k = 0; k < 11; k++) begin
      gap = 0;
      while (!clk_pull) begin gap++; @(negedge clk); end
      got[k] = line_dat;
      lowc = 0;
      while (clk_pull) begin lowc++; @(negedge clk); end
      // R9
      chk(lowc == T_LOW, "R9 clock low", lowc, T_LOW);
      if (k == 0) chk(gap == T_SETUP, "R9 first setup", gap, T_SETUP);
      else chk(gap == T_HIGH + T_SETUP, "R9 pulse gap", gap, T_HIGH + T_SETUP);
    end
    seen = 0;
    for (int i = 0; i < T_HIGH + 4; i++) begin
      if (tx_done) seen = 1;
      @(negedge clk);
    end
    // R8
    chk(got == exp_tx(b), "R8 frame", int'(got), int'(exp_tx(b)));
    chk(seen && !clk_pull && !dat_pull, "R8 done and release", int'(seen), 1);
  endtask

  task automatic recv_byte(input logic [7:0] b, input bit par_flip, input bit stop_bad);
    logic [9:0] bits;
    int gap, lowc, ones;
    bit ack_ok, got_v, got_e;
    logic [7:0] got_d;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    bits = {~stop_bad, (ones % 2 == 0) ^ par_flip, b};
    host_clk = 1'b0;
    repeat (4) @(negedge clk);
    host_dat = 1'b0;
    repeat (2) @(negedge clk);
    host_clk = 1'b1;
    ack_ok = 1;
    for (int k = 0; k < 11; k++) begin
      gap = 0;
      while (!clk_pull) begin gap++; @(negedge clk); end
      host_dat = (k < 10) ? bits[k] : 1'b1;
      lowc = 0;
      while (clk_pull) begin
        if (k == 10 && !dat_pull) ack_ok = 0;
        lowc++; @(negedge clk);
      end
      // R3
      chk(lowc == T_LOW, "R3 clock low", lowc, T_LOW);
      if (k > 0) chk(gap == T_HOLD + T_REST + T_SETUP, "R3 pulse gap", gap,
                     T_HOLD + T_REST + T_SETUP);
      // R2
      if (k == 1) chk(!tx_ready, "R2 busy not ready", int'(tx_ready), 0);
    end
    // R6
    chk(ack_ok, "R6 acknowledge", int'(ack_ok), 1);
    got_v = 0; got_e = 0; got_d = '0;
    for (int i = 0; i < T_HOLD + T_REST + 4; i++) begin
      if (rx_valid) begin got_v = 1; got_d = rx_data; end
      if (rx_err) got_e = 1;
      @(negedge clk);
    end
    if (par_flip || stop_bad) begin
      // R5
      chk(got_e && !got_v, "R5 error flag", int'({got_e, got_v}), 2);
    end else begin
      // R4
      chk(got_v && !got_e && got_d == b, "R4 received byte", int'(got_d), int'(b));
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!clk_pull && !dat_pull && tx_ready && !rx_valid && !rx_err,
        "R1 reset state", int'({clk_pull, dat_pull, tx_ready}), 1);

    // R1 ready low when host holds clock; nothing is sent
    host_clk = 1'b0;
    tx_data = 8'h3C; tx_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(!tx_ready && !clk_pull && !dat_pull, "R1 no start while clock low",
        int'({tx_ready, clk_pull, dat_pull}), 0);
    tx_valid = 1'b0;
    host_clk = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ready, "R1 ready after release", int'(tx_ready), 1);

    for (int v = 0; v < 256; v++) send_byte(8'(v));
    for (int v = 0; v < 256; v++) recv_byte(8'(v), 1'b0, 1'b0);

    recv_byte(8'h00, 1'b1, 1'b0);
    recv_byte(8'hA7, 1'b1, 1'b0);
    recv_byte(8'h5A, 1'b0, 1'b1);
    recv_byte(8'hFF, 1'b1, 1'b1);
    recv_byte(8'h81, 1'b0, 1'b0);

    // R10 abort during the third released phase
    begin
      bit seen, done_seen;
      while (!tx_ready) @(negedge clk);
      tx_data = 8'hA5; tx_valid = 1'b1;
      @(negedge clk); tx_valid = 1'b0;
      for (int p = 0; p < 3; p++) begin
        while (!clk_pull) @(negedge clk);
        while (clk_pull) @(negedge clk);
      end
      @(negedge clk);
      host_clk = 1'b0;
      seen = 0; done_seen = 0;
      for (int i = 0; i < 8; i++) begin
        if (tx_fail) seen = 1;
        if (tx_done) done_seen = 1;
        @(negedge clk);
      end
      chk(seen && !done_seen, "R10 abort strobe", int'(seen), 1);
      chk(!clk_pull && !dat_pull && !tx_ready, "R10 released and not ready",
          int'({clk_pull, dat_pull, tx_ready}), 0);
      repeat (10) @(negedge clk);
      chk(!clk_pull, "R10 no pulse while held", int'(clk_pull), 0);
      host_clk = 1'b1;
      repeat (5) @(negedge clk);
      chk(tx_ready, "R10 ready after release", int'(tx_ready), 1);
    end

    send_byte(8'h5B);
    recv_byte(8'hC3, 1'b0, 1'b0);
    finish_up();
  end

endmodule